// File: doc/BRIEF.md
# Exception Entry Controller

This block turns exception requests into a single, complete exception entry. It watches eight causes: a reset request, an undefined-instruction trap, a software interrupt, a prefetch abort, a data abort, an address exception, an IRQ and an FIQ. It rejects interrupt requests whose disable flag is set and picks one winner by fixed priority. One cycle later it presents everything the processor needs to enter the handler: the link value for R14, the R14 write strobe, the new mode, the new interrupt-disable flags and the vector address for the program counter.

The processor state arrives as one packed 32-bit program-counter/status word. The address field is bits 25:2, giving a 26-bit address space. Bit 27 is IRQ-disable, bit 26 is FIQ-disable, bits 31:28 are the condition flags and bits 1:0 are the mode. The address exception is detected inside the block. It is raised when the first data transfer of an instruction targets a byte address that does not fit in 26 bits.

The controller is a two-state machine. `ST_IDLE` waits for a request that is allowed through. The *grant* transition captures the entry payload and moves to `ST_ENTER`. `ST_ENTER` drives the entry outputs for exactly one cycle. The *finish* transition then always returns to `ST_IDLE`. When no request is allowed through, the *wait* transition keeps the machine in `ST_IDLE`. The mode outputs and the R14 strobe appear in the same cycle. The register file therefore writes the link value into the R14 of the newly selected mode.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The cause codes are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, address exception 5, IRQ 6 and FIQ 7. On entry, `pc_o` equals the cause code times four (0x00 to 0x1C).
- R2: `link_o` keeps bits 31:26 and 1:0 of the `psr_i` value sampled with the request. Bits 25:2 of `link_o` equal bits 25:2 of that value plus 1, wrapping within 24 bits, for prefetch abort, data abort, address exception, IRQ and FIQ. For reset, undefined and software interrupt they are unchanged.
- R3: `mode_o` is 2 for IRQ entry and 1 for FIQ entry. For every other cause it is 3.
- R4: On entry `irq_off_o` is 1. `fiq_off_o` is 1 for reset and FIQ entry. For the other causes it equals bit 26 of the sampled `psr_i`.
- R5: An IRQ request has no effect while `psr_i` bit 27 is set. An FIQ request has no effect while `psr_i` bit 26 is set.
- R6: When several allowed requests are sampled in the same cycle, one wins by this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt, address exception.
- R7: An address exception is requested when `xfer_first_i` is 1 and `xfer_addr_i` exceeds 0x3FFFFFF. An address of 0x3FFFFFF or lower never requests one, and neither does any address while `xfer_first_i` is 0.
- R8: Entry outputs appear in the cycle after the clock edge that samples the request, and `entry_o` stays high for exactly one cycle. Requests sampled during that entry cycle are ignored. A request held high therefore enters on every second cycle.
- R9: `r14_we_o` is high exactly when `entry_o` is high, in the same cycle as `mode_o`. Outside entry cycles, `link_o`, `pc_o`, `mode_o` and both flag outputs are 0.
- R10: After `rst_n` is released and before any request, `entry_o` and `r14_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| req_reset_i | input | 1 | Reset exception request |
| req_undef_i | input | 1 | Undefined-instruction request |
| req_swi_i | input | 1 | Software-interrupt request |
| req_pabort_i | input | 1 | Prefetch-abort request |
| req_dabort_i | input | 1 | Data-abort request |
| req_irq_i | input | 1 | IRQ request |
| req_fiq_i | input | 1 | FIQ request |
| xfer_first_i | input | 1 | The current data transfer is the first of its instruction |
| xfer_addr_i | input | 32 | Byte address of the current data transfer |
| psr_i | input | 32 | Packed program-counter/status word |
| entry_o | output | 1 | One-cycle pulse marking an exception entry |
| link_o | output | 32 | Value to write into R14 of the new mode |
| r14_we_o | output | 1 | R14 write strobe |
| mode_o | output | 2 | New mode (0 user, 1 FIQ, 2 IRQ, 3 supervisor) |
| irq_off_o | output | 1 | New IRQ-disable flag |
| fiq_off_o | output | 1 | New FIQ-disable flag |
| pc_o | output | 32 | Vector address to load into the program counter |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples the request. That edge registers the chosen cause, link value and FIQ-disable flag. The bench changes inputs on falling edges, reads the entry outputs on the following falling edge, and clears the requests at that same point. It then reads once more a falling edge later to confirm that the pulse has dropped. A sweep over all 256 request combinations under all four disable-flag settings compares each result against a priority and arithmetic model. Separate cases cover the 26-bit boundary of the address check, the wrap of the link value, and a request held through the entry cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int NUM_KINDS = 8;
    localparam int KIND_W    = 3;

    typedef enum logic [KIND_W-1:0] {
        EK_RESET = 3'd0,
        EK_UNDEF = 3'd1,
        EK_SWI   = 3'd2,
        EK_PABT  = 3'd3,
        EK_DABT  = 3'd4,
        EK_ADDR  = 3'd5,
        EK_IRQ   = 3'd6,
        EK_FIQ   = 3'd7
    } exc_kind_e;

    typedef enum logic [1:0] {
        MD_USER  = 2'd0,
        MD_FAST  = 2'd1,
        MD_INTR  = 2'd2,
        MD_SUPER = 2'd3
    } cpu_mode_e;

    // Highest priority first.
    localparam exc_kind_e PRIO_ORDER [NUM_KINDS] = '{
        EK_RESET, EK_DABT, EK_FIQ, EK_IRQ, EK_PABT, EK_UNDEF, EK_SWI, EK_ADDR
    };

    function automatic cpu_mode_e mode_for(exc_kind_e k);
        unique case (k)
            EK_IRQ:  return MD_INTR;
            EK_FIQ:  return MD_FAST;
            default: return MD_SUPER;
        endcase
    endfunction

    // Causes whose link value points one word past the stored PC.
    function automatic logic skips_word(exc_kind_e k);
        return (k >= EK_PABT);
    endfunction

    function automatic logic masks_fiq(exc_kind_e k);
        return (k == EK_RESET) || (k == EK_FIQ);
    endfunction

endpackage

// File: rtl/exc_addr_chk.sv
module exc_addr_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 26,
    localparam int HI_W  = WORD_W - ADDR_W
) (
    input  logic            first_i,
    input  logic [HI_W-1:0] high_bits_i,
    output logic            fault_o
);
    // Any set bit above the 26-bit address space on a first transfer is a fault.
    assign fault_o = first_i && (high_bits_i != '0);
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic [NUM_KINDS-1:0] req_i,
    input  logic                 irq_off_i,
    input  logic                 fiq_off_i,
    output logic                 valid_o,
    output exc_kind_e            kind_o
);
    logic [NUM_KINDS-1:0] allowed;

    always_comb begin
        allowed          = req_i;
        allowed[EK_IRQ]  = req_i[EK_IRQ] && !irq_off_i;
        allowed[EK_FIQ]  = req_i[EK_FIQ] && !fiq_off_i;
    end

    // Walk from lowest to highest priority so the highest allowed request wins.
    always_comb begin
        valid_o = 1'b0;
        kind_o  = EK_RESET;
        for (int i = NUM_KINDS - 1; i >= 0; i--) begin
            if (allowed[PRIO_ORDER[i]]) begin
                valid_o = 1'b1;
                kind_o  = PRIO_ORDER[i];
            end
        end
    end
endmodule

// File: rtl/exc_link_calc.sv
module exc_link_calc
    import exc_entry_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 26,
    localparam int FIELD_W = ADDR_W - 2
) (
    input  logic [WORD_W-1:0] psr_i,
    input  exc_kind_e         kind_i,
    output logic [WORD_W-1:0] link_o
);
    logic [FIELD_W-1:0] word_addr;

    always_comb begin
        word_addr = psr_i[ADDR_W-1:2] + FIELD_W'(skips_word(kind_i));
        link_o    = psr_i;
        link_o[ADDR_W-1:2] = word_addr;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset_i,
    input  logic              req_undef_i,
    input  logic              req_swi_i,
    input  logic              req_pabort_i,
    input  logic              req_dabort_i,
    input  logic              req_irq_i,
    input  logic              req_fiq_i,
    input  logic              xfer_first_i,
    input  logic [WORD_W-1:0] xfer_addr_i,
    input  logic [WORD_W-1:0] psr_i,
    output logic              entry_o,
    output logic [WORD_W-1:0] link_o,
    output logic              r14_we_o,
    output logic [1:0]        mode_o,
    output logic              irq_off_o,
    output logic              fiq_off_o,
    output logic [WORD_W-1:0] pc_o
);
    localparam int BIT_FIQ_OFF = ADDR_W;
    localparam int BIT_IRQ_OFF = ADDR_W + 1;

    typedef enum logic {
        ST_IDLE,
        ST_ENTER
    } entry_state_e;

    entry_state_e         st_q, st_d;
    exc_kind_e            kind_q;
    logic [WORD_W-1:0]    link_q;
    logic                 fiq_q;

    logic                 addr_fault;
    logic [NUM_KINDS-1:0] req_vec;
    logic                 grant_valid;
    exc_kind_e            grant_kind;
    logic [WORD_W-1:0]    link_next;

    exc_addr_chk #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_addr_chk (
        .first_i     (xfer_first_i),
        .high_bits_i (xfer_addr_i[WORD_W-1:ADDR_W]),
        .fault_o     (addr_fault)
    );

    always_comb begin
        req_vec           = '0;
        req_vec[EK_RESET] = req_reset_i;
        req_vec[EK_UNDEF] = req_undef_i;
        req_vec[EK_SWI]   = req_swi_i;
        req_vec[EK_PABT]  = req_pabort_i;
        req_vec[EK_DABT]  = req_dabort_i;
        req_vec[EK_ADDR]  = addr_fault;
        req_vec[EK_IRQ]   = req_irq_i;
        req_vec[EK_FIQ]   = req_fiq_i;
    end

    exc_arbiter u_arbiter (
        .req_i     (req_vec),
        .irq_off_i (psr_i[BIT_IRQ_OFF]),
        .fiq_off_i (psr_i[BIT_FIQ_OFF]),
        .valid_o   (grant_valid),
        .kind_o    (grant_kind)
    );

    exc_link_calc #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_link_calc (
        .psr_i  (psr_i),
        .kind_i (grant_kind),
        .link_o (link_next)
    );

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (grant_valid) st_d = ST_ENTER;
            ST_ENTER: st_d = ST_IDLE;
        endcase
    end

    // State register and entry payload.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= EK_RESET;
            link_q <= '0;
            fiq_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && grant_valid) begin
                kind_q <= grant_kind;
                link_q <= link_next;
                fiq_q  <= psr_i[BIT_FIQ_OFF] || masks_fiq(grant_kind);
            end
        end
    end

    // Outputs.
    always_comb begin
        entry_o   = 1'b0;
        r14_we_o  = 1'b0;
        link_o    = '0;
        mode_o    = MD_USER;
        irq_off_o = 1'b0;
        fiq_off_o = 1'b0;
        pc_o      = '0;
        unique case (st_q)
            ST_IDLE: ;
            ST_ENTER: begin
                entry_o   = 1'b1;
                r14_we_o  = 1'b1;
                link_o    = link_q;
                mode_o    = mode_for(kind_q);
                irq_off_o = 1'b1;
                fiq_off_o = fiq_q;
                pc_o      = WORD_W'({kind_q, 2'b00});
            end
        endcase
    end

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> !entry_o); // R8

    AST_NO_SPONTANEOUS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry_o && req_vec == '0) |=> !entry_o); // R8

    AST_IRQ_OFF_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> irq_off_o); // R4

    AST_MASKED_IRQ_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_kind == EK_IRQ) |-> !psr_i[BIT_IRQ_OFF]); // R5

    AST_MASKED_FIQ_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_kind == EK_FIQ) |-> !psr_i[BIT_FIQ_OFF]); // R5

    AST_FIQ_VECTOR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_o && pc_o == WORD_W'(32'h1C)) |-> (mode_o == MD_FAST && fiq_off_o)); // R3

    AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> (pc_o[1:0] == 2'b00 && pc_o < WORD_W'(32)));  // R1

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_reset_i = 0, req_undef_i = 0, req_swi_i = 0, req_pabort_i = 0;
    logic        req_dabort_i = 0, req_irq_i = 0, req_fiq_i = 0;
    logic        xfer_first_i = 0;
    logic [31:0] xfer_addr_i = '0;
    logic [31:0] psr_i = '0;
    logic        entry_o, r14_we_o, irq_off_o, fiq_off_o;
    logic [31:0] link_o, pc_o;
    logic [1:0]  mode_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_reset_i (req_reset_i), .req_undef_i (req_undef_i), .req_swi_i (req_swi_i),
        .req_pabort_i (req_pabort_i), .req_dabort_i (req_dabort_i),
        .req_irq_i (req_irq_i), .req_fiq_i (req_fiq_i),
        .xfer_first_i (xfer_first_i), .xfer_addr_i (xfer_addr_i), .psr_i (psr_i),
        .entry_o (entry_o), .link_o (link_o), .r14_we_o (r14_we_o), .mode_o (mode_o),
        .irq_off_o (irq_off_o), .fiq_off_o (fiq_off_o), .pc_o (pc_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Bits: 0 reset, 1 undef, 2 swi, 3 pabort, 4 dabort, 5 address, 6 irq, 7 fiq.
    function automatic int pick(input logic [7:0] rq, input logic ioff, input logic foff);
        if (rq[0]) return 0;
        if (rq[4]) return 4;
        if (rq[7] && !foff) return 7;
        if (rq[6] && !ioff) return 6;
        if (rq[3]) return 3;
        if (rq[1]) return 1;
        if (rq[2]) return 2;
        if (rq[5]) return 5;
        return -1;
    endfunction

    task automatic apply(input logic [7:0] rq, input logic [31:0] psr,
                         input logic xf, input logic [31:0] xa);
        req_reset_i  = rq[0]; req_undef_i = rq[1]; req_swi_i = rq[2];
        req_pabort_i = rq[3]; req_dabort_i = rq[4];
        req_irq_i    = rq[6]; req_fiq_i = rq[7];
        xfer_first_i = xf; xfer_addr_i = xa; psr_i = psr;
    endtask

    task automatic idle_inputs();
        apply(8'h00, 32'h0, 1'b0, 32'h0);
    endtask

    // Applies a stimulus, checks the entry cycle against the model, then the following quiet cycle.
    task automatic run_case(input logic [7:0] rq, input logic [31:0] psr,
                            input logic xf, input logic [31:0] xa, input logic addr_req);
        logic [7:0]  eff;
        int          k;
        logic [31:0] exp_link;
        logic [1:0]  exp_mode;
        eff    = rq;
        eff[5] = addr_req;
        k      = pick(eff, psr[27], psr[26]);
        @(negedge clk);
        apply(rq, psr, xf, xa);
        @(negedge clk);
        idle_inputs();
        if (k < 0) begin
            chk("R5/R7 no entry", {31'b0, entry_o}, 32'd0);
            chk("R9 idle link zero", link_o, 32'd0);
        end else begin
            exp_link = psr;
            exp_link[25:2] = psr[25:2] + ((k >= 3) ? 24'd1 : 24'd0);
            exp_mode = (k == 6) ? 2'd2 : (k == 7) ? 2'd1 : 2'd3;
            chk("R6 entry", {31'b0, entry_o}, 32'd1);
            chk("R1/R6 vector", pc_o, 32'(k * 4));
            chk("R2 link", link_o, exp_link);
            chk("R3 mode", {30'b0, mode_o}, {30'b0, exp_mode});
            chk("R4 irq_off", {31'b0, irq_off_o}, 32'd1);
            chk("R4 fiq_off", {31'b0, fiq_off_o},
                {31'b0, (k == 0 || k == 7) ? 1'b1 : psr[26]});
            chk("R9 r14_we", {31'b0, r14_we_o}, 32'd1);
        end
        @(negedge clk);
        chk("R8 pulse dropped", {31'b0, entry_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        logic [31:0] psr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 entry after reset", {31'b0, entry_o}, 32'd0);
        chk("R10 r14_we after reset", {31'b0, r14_we_o}, 32'd0);

        // Exhaustive sweep: all request combinations under all disable settings (R1-R6 model).
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 256; r++) begin
                psr = {r[3:0], m[1], m[0], (r[7:0] * 24'h01F3A7) ^ {m[1:0], 22'h2A5C1}, r[5:4]};
                if (r[5])
                    run_case(r[7:0], psr, 1'b1, 32'h0400_0000 | (r << 8), 1'b1);
                else
                    run_case(r[7:0], psr, r[0], 32'h03FF_FFFC, 1'b0);
            end
        end

        // R7: boundary of the 26-bit space and the first-transfer qualifier.
        run_case(8'h00, 32'h0000_1000, 1'b1, 32'h03FF_FFFF, 1'b0); // R7 highest legal address
        run_case(8'h00, 32'h0000_1000, 1'b1, 32'h0400_0000, 1'b1); // R7 first illegal address
        run_case(8'h00, 32'h0000_1000, 1'b0, 32'hFFFF_FFFF, 1'b0); // R7 not first transfer
        run_case(8'h00, 32'h0000_1000, 1'b1, 32'h8000_0000, 1'b1); // R7 top bit only

        // R2: link address field wraps within 26 bits.
        run_case(8'h08, 32'hF3FF_FFFE, 1'b0, 32'h0, 1'b0);

        // R5: masked IRQ alone, and masked FIQ alone.
        run_case(8'h40, 32'h0800_0100, 1'b0, 32'h0, 1'b0);
        run_case(8'h80, 32'h0400_0100, 1'b0, 32'h0, 1'b0);

        // R8: a request held high enters on every second cycle.
        @(negedge clk);
        apply(8'h02, 32'h0000_0040, 1'b0, 32'h0);
        @(negedge clk);
        chk("R8 held first entry", {31'b0, entry_o}, 32'd1);
        @(negedge clk);
        chk("R8 held request ignored in entry cycle", {31'b0, entry_o}, 32'd0);
        @(negedge clk);
        chk("R8 held second entry", {31'b0, entry_o}, 32'd1);
        chk("R8 held second vector", pc_o, 32'h04);
        idle_inputs();
        @(negedge clk);
        chk("R9 idle pc zero", pc_o, 32'd0);
        chk("R9 idle mode zero", {30'b0, mode_o}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule